// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM array alive. After reset it holds the RAS and CAS strobes inactive for a long power-up pause. It then runs a fixed burst of warm-up refresh cycles and raises `init_done`. From then on an interval timer adds one owed refresh at each period. With the default 200 MHz timing that period is 15.6 µs, so 2048 refreshes fit in every 32 ms. The block pays off what it owes through a request/grant handshake with the normal access controller.

Two refresh styles are supported. The strobe-order style drops CAS first and then RAS, while WE stays high, and the DRAM supplies the row internally. The row-strobe style keeps CAS high and pulses RAS. The row comes from an internal counter that advances after every such cycle and wraps at the top of the row space. The style is sampled at the start of each refresh cycle. Owed refreshes may pile up while the controller is busy, up to a limit. At that limit `ref_urgent` tells the controller to start no new accesses. A run of strobe-order refreshes leaves CAS low between cycles.

All strobe timings are counts of clock cycles: CAS-to-RAS setup, RAS low width, RAS precharge and full cycle time. The RAS low phase is stretched when needed so that low time plus precharge covers the cycle time.

Top module: `dram_refresh_seq`

## Requirements
- R1: During and right after reset, `ras_n`, `cas_n` and `we_n` are 1, and `ref_req`, `ref_urgent` and `init_done` are 0.
- R2: No strobe goes low during the first PAUSE_CYCLES clock cycles after reset. `ref_req` stays 0 as long as `init_done` is 0.
- R3: After the pause, exactly WARMUP_COUNT refresh cycles (RAS falling edges) run before `init_done` rises. No grant is needed for them, and `init_done` then stays 1 until reset.
- R4: With `ras_only_mode` = 0, every RAS falling edge finds `cas_n` already low in the previous cycle and `we_n` high.
- R5: With `ras_only_mode` = 1, `cas_n` stays 1 throughout and `row_addr` is stable while RAS is low. The first row-strobe cycle after reset uses row 0. Each following one uses the previous row plus one, modulo 2^ROW_BITS.
- R6: RAS stays low for at least RAS_CYCLES and at least RC_CYCLES−RP_CYCLES cycles. It stays high for at least RP_CYCLES cycles between two low pulses.
- R7: After `init_done`, one refresh becomes owed every INTERVAL_CYCLES cycles. With `bus_gnt` held at 1, a window of 10·INTERVAL_CYCLES cycles that starts at a RAS fall holds exactly 10 further RAS falls.
- R8: The owed count saturates at OWED_MAX. `ref_urgent` is 1 while the count is at OWED_MAX and drops once a refresh has been paid off.
- R9: After `init_done`, `ref_req` is 1 whenever a refresh is owed or one is in progress. No strobe moves while `bus_gnt` is 0 and the block is waiting. `ref_req` drops after the last precharge once nothing is owed.
- R10: While consecutive strobe-order refreshes are owed and `bus_gnt` stays 1, CAS stays low from the first RAS fall through the RAS low phase of the last chained cycle. The same holds during warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_mode | input | 1 | 1 = row-strobe refresh with internal row, 0 = CAS-first refresh |
| bus_gnt | input | 1 | Access controller grants the DRAM bus (access path idle) |
| ref_req | output | 1 | Refresh wants or holds the bus |
| ref_urgent | output | 1 | Owed count at its limit; controller must start no new access |
| init_done | output | 1 | Power-up pause and warm-up complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high by refresh) |
| row_addr | output | ROW_BITS | Row presented during row-strobe refresh |

## Verification
On every cycle, the assertions check these properties:
- the quiet power-up window;
- the strobe order at each RAS fall;
- the minimum RAS low and precharge widths;
- row stability and the row increment in row-strobe mode;
- the limit on the owed count;
- the rule that no RAS falls after initialization without `ref_req`.

Some properties need a whole window of time and only the bench scenarios show them:
- the warm-up count;
- the refresh rate over a scaled window;
- saturation after a long denied grant;
- the back-to-back burst that keeps CAS low;
- the wrap of the row counter.

// File: rtl/dram_ref_pkg.sv
`timescale 1ns/1ps
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_WAIT,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRECH
  } ref_state_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ref_pace_timer.sv
`timescale 1ns/1ps
module ref_pace_timer #(
  parameter int PAUSE_CYCLES    = 40000,
  parameter int INTERVAL_CYCLES = 3120
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic pause_done,
  output logic tick
);
  localparam int PW = $clog2(PAUSE_CYCLES + 1);
  localparam int IW = $clog2(INTERVAL_CYCLES + 1);

  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] ivl_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_cnt  <= '0;
      pause_done <= 1'b0;
      ivl_cnt    <= '0;
      tick       <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (!pause_done) begin
        if (pause_cnt == PW'(PAUSE_CYCLES - 1)) pause_done <= 1'b1;
        else                                     pause_cnt  <= pause_cnt + 1'b1;
      end
      if (!run) begin
        ivl_cnt <= '0;
      end else if (ivl_cnt == IW'(INTERVAL_CYCLES - 1)) begin
        ivl_cnt <= '0;
        tick    <= 1'b1;
      end else begin
        ivl_cnt <= ivl_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ref_owed_ctr.sv
`timescale 1ns/1ps
module ref_owed_ctr #(
  parameter int OWED_MAX = 8,
  localparam int OW = $clog2(OWED_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [OW-1:0] owed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      owed <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (owed != OW'(OWED_MAX)) owed <= owed + 1'b1;
        2'b01:   if (owed != '0)            owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end
endmodule

// File: rtl/ref_cycle_fsm.sv
`timescale 1ns/1ps
module ref_cycle_fsm
  import dram_ref_pkg::*;
#(
  parameter int ROW_BITS     = 11,
  parameter int WARMUP_COUNT = 8,
  parameter int SETUP_CYCLES = 2,
  parameter int RAS_CYCLES   = 12,
  parameter int RP_CYCLES    = 8,
  parameter int RC_CYCLES    = 21
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pause_done,
  input  logic                owed_nz,
  input  logic                owed_multi,
  input  logic                bus_gnt,
  input  logic                ras_only_mode,
  output logic                ref_req,
  output logic                init_done,
  output logic                served,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int ACT_CYCLES = max_int(RAS_CYCLES, RC_CYCLES - RP_CYCLES);
  localparam int CW = $clog2(max_int(max_int(SETUP_CYCLES, ACT_CYCLES), RP_CYCLES) + 1);
  localparam int WW = $clog2(WARMUP_COUNT + 1);

  ref_state_t    state;
  logic [CW-1:0] cnt;
  logic [WW-1:0] warm_cnt;
  logic          use_ror;
  logic          last_warm;
  logic          keep_cas;

  // Chaining: CAS stays low across the precharge if another strobe-order
  // cycle is certain to follow.
  always_comb begin
    last_warm = (warm_cnt == WW'(WARMUP_COUNT - 1));
    keep_cas  = !use_ror && (init_done ? (owed_multi && bus_gnt) : !last_warm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PAUSE;
      cnt       <= '0;
      warm_cnt  <= '0;
      use_ror   <= 1'b0;
      ref_req   <= 1'b0;
      init_done <= 1'b0;
      served    <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      row_addr  <= '0;
    end else begin
      served <= 1'b0;
      we_n   <= 1'b1;
      case (state)
        ST_PAUSE: begin
          if (pause_done) begin
            state   <= ST_SETUP;
            cnt     <= CW'(SETUP_CYCLES - 1);
            use_ror <= ras_only_mode;
            cas_n   <= ras_only_mode;
          end
        end
        ST_WAIT: begin
          ref_req <= owed_nz;
          cas_n   <= 1'b1;
          if (ref_req && bus_gnt) begin
            ref_req <= 1'b1;
            state   <= ST_SETUP;
            cnt     <= CW'(SETUP_CYCLES - 1);
            use_ror <= ras_only_mode;
            cas_n   <= ras_only_mode;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_ACTIVE;
            ras_n <= 1'b0;
            cnt   <= CW'(ACT_CYCLES - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (cnt == '0) begin
            state <= ST_PRECH;
            ras_n <= 1'b1;
            cnt   <= CW'(RP_CYCLES - 1);
            cas_n <= !keep_cas;
            if (use_ror)   row_addr <= row_addr + 1'b1;
            if (init_done) served   <= 1'b1;
            else           warm_cnt <= warm_cnt + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRECH: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!init_done) begin
            if (warm_cnt == WW'(WARMUP_COUNT)) begin
              init_done <= 1'b1;
              state     <= ST_WAIT;
              cas_n     <= 1'b1;
            end else begin
              state   <= ST_SETUP;
              cnt     <= CW'(SETUP_CYCLES - 1);
              use_ror <= ras_only_mode;
              cas_n   <= ras_only_mode;
            end
          end else if (owed_nz && bus_gnt) begin
            state   <= ST_SETUP;
            cnt     <= CW'(SETUP_CYCLES - 1);
            use_ror <= ras_only_mode;
            cas_n   <= ras_only_mode;
          end else begin
            state   <= ST_WAIT;
            ref_req <= owed_nz;
            cas_n   <= 1'b1;
          end
        end
        default: state <= ST_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
module dram_refresh_seq #(
  parameter int PAUSE_CYCLES    = 40000,
  parameter int INTERVAL_CYCLES = 3120,
  parameter int WARMUP_COUNT    = 8,
  parameter int OWED_MAX        = 8,
  parameter int ROW_BITS        = 11,
  parameter int SETUP_CYCLES    = 2,
  parameter int RAS_CYCLES      = 12,
  parameter int RP_CYCLES       = 8,
  parameter int RC_CYCLES       = 21
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_only_mode,
  input  logic                bus_gnt,
  output logic                ref_req,
  output logic                ref_urgent,
  output logic                init_done,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int OWED_W = $clog2(OWED_MAX + 1);

  logic              pause_done;
  logic              tick;
  logic              served;
  logic [OWED_W-1:0] owed;

  ref_pace_timer #(
    .PAUSE_CYCLES   (PAUSE_CYCLES),
    .INTERVAL_CYCLES(INTERVAL_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (init_done),
    .pause_done(pause_done),
    .tick      (tick)
  );

  ref_owed_ctr #(
    .OWED_MAX(OWED_MAX)
  ) u_owed (
    .clk (clk),
    .rst (rst),
    .inc (tick),
    .dec (served),
    .owed(owed)
  );

  ref_cycle_fsm #(
    .ROW_BITS    (ROW_BITS),
    .WARMUP_COUNT(WARMUP_COUNT),
    .SETUP_CYCLES(SETUP_CYCLES),
    .RAS_CYCLES  (RAS_CYCLES),
    .RP_CYCLES   (RP_CYCLES),
    .RC_CYCLES   (RC_CYCLES)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .pause_done   (pause_done),
    .owed_nz      (owed != '0),
    .owed_multi   (owed > OWED_W'(1)),
    .bus_gnt      (bus_gnt),
    .ras_only_mode(ras_only_mode),
    .ref_req      (ref_req),
    .init_done    (init_done),
    .served       (served),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .row_addr     (row_addr)
  );

  assign ref_urgent = (owed == OWED_W'(OWED_MAX));
endmodule

// File: rtl/dram_refresh_chk.sv
`timescale 1ns/1ps
module dram_refresh_chk #(
  parameter int PAUSE_CYCLES = 40000,
  parameter int RAS_CYCLES   = 12,
  parameter int RP_CYCLES    = 8,
  parameter int RC_CYCLES    = 21,
  parameter int OWED_MAX     = 8,
  parameter int ROW_BITS     = 11,
  localparam int OW = $clog2(OWED_MAX + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                ras_n,
  input logic                cas_n,
  input logic                ref_req,
  input logic                ref_urgent,
  input logic                init_done,
  input logic [ROW_BITS-1:0] row_addr,
  input logic [OW-1:0]       owed
);
  localparam int LIM = RC_CYCLES + RAS_CYCLES;
  localparam int LW  = $clog2(LIM + 1);
  localparam int SW  = $clog2(PAUSE_CYCLES + 1);

  logic [SW-1:0]       since_rst;
  logic [LW-1:0]       hi_cnt;
  logic [LW-1:0]       lo_cnt;
  logic                prev_ras;
  logic [ROW_BITS-1:0] exp_row;
  logic                ror_fall;

  assign ror_fall = prev_ras && !ras_n && cas_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      hi_cnt    <= LW'(RP_CYCLES);
      lo_cnt    <= '0;
      prev_ras  <= 1'b1;
      exp_row   <= '0;
    end else begin
      if (since_rst != SW'(PAUSE_CYCLES)) since_rst <= since_rst + 1'b1;
      if (ras_n) begin
        lo_cnt <= '0;
        if (hi_cnt != LW'(LIM)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != LW'(LIM)) lo_cnt <= lo_cnt + 1'b1;
      end
      prev_ras <= ras_n;
      if (ror_fall) exp_row <= row_addr + 1'b1;
    end
  end

  p_quiet_pause_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst < SW'(PAUSE_CYCLES)) |-> (ras_n && cas_n));

  p_no_req_before_init_r2: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !ref_req);

  p_init_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_cas_first_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  p_cas_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $past(!ras_n)) |-> $stable(cas_n));

  p_row_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $past(!ras_n)) |-> $stable(row_addr));

  p_row_step_r5: assert property (@(posedge clk) disable iff (rst)
    ror_fall |-> (row_addr == exp_row));

  p_ras_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (lo_cnt >= LW'(RAS_CYCLES) && lo_cnt >= LW'(RC_CYCLES - RP_CYCLES)));

  p_precharge_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_cnt >= LW'(RP_CYCLES)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    owed <= OW'(OWED_MAX));

  p_urgent_after_init_r8: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> init_done);

  p_req_holds_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (init_done && $fell(ras_n)) |-> ref_req);
endmodule

bind dram_refresh_seq dram_refresh_chk #(
  .PAUSE_CYCLES(PAUSE_CYCLES),
  .RAS_CYCLES  (RAS_CYCLES),
  .RP_CYCLES   (RP_CYCLES),
  .RC_CYCLES   (RC_CYCLES),
  .OWED_MAX    (OWED_MAX),
  .ROW_BITS    (ROW_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .ref_req   (ref_req),
  .ref_urgent(ref_urgent),
  .init_done (init_done),
  .row_addr  (row_addr),
  .owed      (owed)
);

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;
  localparam int PAUSE = 200;
  localparam int INTV  = 120;
  localparam int WARM  = 8;
  localparam int OMAX  = 8;
  localparam int RB    = 5;
  localparam int SETUP = 2;
  localparam int RASW  = 12;
  localparam int RP    = 8;
  localparam int RC    = 21;
  localparam int ACT   = (RC - RP > RASW) ? RC - RP : RASW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode = 1'b0;
  logic          gnt = 1'b0;
  logic          ref_req, ref_urgent, init_done, ras_n, cas_n, we_n;
  logic [RB-1:0] row_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYCLES(PAUSE), .INTERVAL_CYCLES(INTV), .WARMUP_COUNT(WARM),
    .OWED_MAX(OMAX), .ROW_BITS(RB), .SETUP_CYCLES(SETUP),
    .RAS_CYCLES(RASW), .RP_CYCLES(RP), .RC_CYCLES(RC)
  ) u_dram_refresh_seq (
    .clk(clk), .rst(rst), .ras_only_mode(mode), .bus_gnt(gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .init_done(init_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int lim = 0;
    do begin
      @(negedge clk);
      lim++;
    end while (!(!ref_req && ras_n && cas_n) && lim < 5000);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(ras_n == 1'b1,      "R1 ras_n",      ras_n,      1);
    check(cas_n == 1'b1,      "R1 cas_n",      cas_n,      1);
    check(we_n == 1'b1,       "R1 we_n",       we_n,       1);
    check(ref_req == 1'b0,    "R1 ref_req",    ref_req,    0);
    check(ref_urgent == 1'b0, "R1 ref_urgent", ref_urgent, 0);
    check(init_done == 1'b0,  "R1 init_done",  init_done,  0);
    rst = 1'b0;
  endtask

  task automatic t_init();
    int   cyc = 0, falls = 0, first_cas = -1, cas_hi = 0, bad_order = 0;
    bit   req_seen = 1'b0;
    logic pr = 1'b1, pc = 1'b1;
    while (!init_done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (!cas_n && first_cas < 0) first_cas = cyc;
      if (pr && !ras_n) begin
        falls++;
        if (!(pc == 1'b0 && cas_n == 1'b0 && we_n == 1'b1)) bad_order++;
      end
      if (first_cas >= 0 && falls < WARM && cas_n) cas_hi++;
      if (ref_req) req_seen = 1'b1;
      pr = ras_n;
      pc = cas_n;
    end
    check(first_cas >= PAUSE, "R2 pause before first strobe", first_cas, PAUSE);
    check(!req_seen,          "R2 ref_req during init",       int'(req_seen), 0);
    check(falls == WARM,      "R3 warm-up cycle count",       falls, WARM);
    check(bad_order == 0,     "R4 CAS-first order in warm-up", bad_order, 0);
    check(cas_hi == 0,        "R10 CAS held low in warm-up",  cas_hi, 0);
    repeat (20) @(negedge clk);
    check(init_done == 1'b1,  "R3 init_done sticky",          init_done, 1);
  endtask

  task automatic t_rate();
    int   lim = 0, falls = 0;
    logic pr;
    gnt = 1'b1;
    pr  = ras_n;
    do begin
      @(negedge clk);
      lim++;
      if (pr && !ras_n) falls = 1;
      pr = ras_n;
    end while (falls == 0 && lim < 1000);
    falls = 0;
    repeat (10 * INTV) begin
      @(negedge clk);
      if (pr && !ras_n) falls++;
      pr = ras_n;
    end
    check(falls == 10, "R7 refreshes per 10 intervals", falls, 10);
  endtask

  task automatic t_postpone();
    int   falls = 0, cyc = 0, cas_hi = 0, lo = 0, hi = 0;
    int   min_lo = 1000, min_hi = 1000;
    logic pr;
    wait_idle();
    gnt = 1'b0;
    pr  = ras_n;
    repeat (10 * INTV) begin
      @(negedge clk);
      if (pr && !ras_n) falls++;
      pr = ras_n;
    end
    check(falls == 0,         "R9 no strobe without grant", falls, 0);
    check(ref_req == 1'b1,    "R9 ref_req while owed",      ref_req, 1);
    check(ref_urgent == 1'b1, "R8 urgent at owed limit",    ref_urgent, 1);
    gnt   = 1'b1;
    falls = 0;
    while ((ref_req || falls == 0) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (pr && !ras_n) begin
        falls++;
        if (falls > 1 && hi < min_hi) min_hi = hi;
        lo = 0;
      end
      if (!pr && ras_n) begin
        if (lo < min_lo) min_lo = lo;
        hi = 0;
      end
      if (!ras_n) lo++;
      else        hi++;
      if (falls >= 1 && (falls < OMAX || (falls == OMAX && !ras_n)) && cas_n) cas_hi++;
      pr = ras_n;
    end
    check(falls >= OMAX,      "R8 saturated backlog paid", falls, OMAX);
    check(cas_hi == 0,        "R10 CAS low across burst",  cas_hi, 0);
    check(min_lo >= ACT,      "R6 RAS low width",          min_lo, ACT);
    check(min_hi >= RP,       "R6 RAS precharge width",    min_hi, RP);
    check(ref_urgent == 1'b0, "R8 urgent cleared",         ref_urgent, 0);
  endtask

  task automatic t_row_only();
    int            falls = 0, cyc = 0, bad_cas = 0, bad_row = 0, first_row = -1;
    bit            wrapped = 1'b0;
    logic [RB-1:0] exp_row = '0;
    logic          pr;
    wait_idle();
    mode = 1'b1;
    pr   = ras_n;
    while (falls < 40 && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (!cas_n) bad_cas++;
      if (pr && !ras_n) begin
        falls++;
        if (first_row < 0) first_row = int'(row_addr);
        if (row_addr != exp_row) bad_row++;
        if (falls > 1 && row_addr == '0) wrapped = 1'b1;
        exp_row = row_addr + 1'b1;
      end
      pr = ras_n;
    end
    check(bad_cas == 0,   "R5 CAS high in row-strobe mode", bad_cas, 0);
    check(first_row == 0, "R5 first row",                   first_row, 0);
    check(bad_row == 0,   "R5 row increments",              bad_row, 0);
    check(wrapped,        "R5 row wraps to 0",              int'(wrapped), 1);
    check(falls == 40,    "R7 row-strobe refresh count",    falls, 40);
  endtask

  initial begin
    t_reset();
    t_init();
    t_rate();
    t_postpone();
    t_row_only();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule